// File: doc/BRIEF.md
# Byte-Write, Word-Read Serial Register Port

This block is the serial front end of a sensor-style register bank. An external controller drives a four-wire serial bus with the clock idling high. Data is launched on the falling edge and captured on the rising edge (polarity 1, phase 1), and each transfer is framed by an active-low select. Every frame is 16 bits, most significant bit first. Bit 15 is the direction flag (1 write, 0 read). Bit 14 is ignored. Bits 13:8 are a 6-bit byte address and bits 7:0 are the payload.

A write frame changes one byte of one 16-bit register. The register index is the upper five address bits. Address bit 0 picks the byte lane: 0 is the low byte, 1 is the high byte. A read frame only names a register, and that register's 16-bit value is shifted back during the following frame. The bus is therefore full duplex: each frame returns the answer to the previous command while it carries a new one.

The register contents live outside the block and arrive on a flat input bus. Writes leave the block as a one-cycle strobe carrying index, lane and byte. For registers whose flags clear when read (such as a new-data flag in bit 15 of a sample register, or a sticky status word), the block pulses a per-register read-acknowledge once the full response has left on the bus, so the owner can clear those flags. All bus pins are sampled into the system clock domain, which must run at least four times faster than the serial clock.

Top module: `regbus_spi_slave`

## Requirements
- R1: After reset, `wr_stb`, `rd_ack` and `spi_miso` are 0, and the first complete frame after reset shifts out sixteen zero bits.
- R2: A complete 16-clock frame with bit 15 = 1 and a writable byte address gives exactly one `wr_stb` pulse. That pulse carries `wr_idx` = address[5:1], `wr_hi` = address[0] and `wr_byte` = frame bits 7:0, and frame bit 14 has no effect on it.
- R3: Writes to read-only addresses (0x00 to 0x11 and 0x3C to 0x3D) produce no `wr_stb`.
- R4: Writes to the unused addresses 0x1C to 0x1F and 0x2A to 0x2F produce no `wr_stb`.
- R5: After a complete read frame (bit 15 = 0), the next frame shifts out on `spi_miso` the 16-bit register at index address[5:1], MSB first, with one bit valid at each rising serial clock edge. Address bit 0 is ignored for reads.
- R6: A read aimed at a write-only register (addresses 0x3A to 0x3B and 0x3E to 0x3F) or at an unused address returns 0x0000.
- R7: A frame that does not contain exactly 16 rising serial clock edges is discarded. It produces no write and no acknowledge, and it leaves the pending read selection unchanged, so the next complete frame returns the register named before it.
- R8: The frame that follows a complete write frame shifts out 0x0000.
- R9: When a complete frame ends that shifted out a clear-on-read register (addresses 0x00 to 0x11 and 0x3C to 0x3D), `rd_ack` shows a single-cycle pulse on that register's bit only. Readable registers outside that set get no pulse.
- R10: Each complete frame carries out its own command (write or read selection) in the same frame that returns the previous read.
- R11: The response value is taken from `reg_values` when the response frame begins, so a change made between the command frame and the response frame is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the controller |
| reg_values | input | 512 | 32 registers of 16 bits, register i at bits [16i+15:16i] |
| spi_miso | output | 1 | Serial data to the controller |
| wr_stb | output | 1 | One-cycle byte write strobe |
| wr_idx | output | 5 | Register index of the write |
| wr_hi | output | 1 | Byte lane of the write, 1 = high byte |
| wr_byte | output | 8 | Byte value to write |
| rd_ack | output | 32 | One-cycle pulse per clear-on-read register after a full response |

## Verification
Almost all state in this block is a pending read selection or a frame bit counter. A wrong selection shows up only one frame later, as a wrong 16-bit word on `spi_miso`, and a wrong counter shows up a few system clocks after select rises, as a stray or missing `wr_stb` or `rd_ack`. Because of this, the bench keeps its own pending-read model and checks every returned word bit by bit. It also checks every strobe and acknowledge on the clock where it appears. The key cases are the chains between frames: read then write, write then read, a short frame placed between a command and its answer, and a flag clear that must show up in the next read of the same register.

// File: rtl/regbus_spi_pkg.sv
package regbus_spi_pkg;

  // Access class of one register, from its read and write permissions
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_WO   = 2'd2,
    ACC_RW   = 2'd3
  } access_e;

  function automatic access_e access_of(input logic rd_ok, input logic wr_ok);
    return access_e'({wr_ok, rd_ok});
  endfunction

  function automatic logic access_writes(input access_e a);
    return (a == ACC_WO) || (a == ACC_RW);
  endfunction

endpackage

// File: rtl/regbus_spi_sync.sv
module regbus_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic cs_fall,
  output logic cs_rise,
  output logic din_s
);

  logic [STAGES-1:0] sclk_q, cs_q, din_q;
  logic              sclk_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '1;
      cs_q   <= '1;
      din_q  <= '0;
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk};
      cs_q   <= {cs_q[STAGES-2:0], cs_n};
      din_q  <= {din_q[STAGES-2:0], din};
      sclk_d <= sclk_q[STAGES-1];
      cs_d   <= cs_q[STAGES-1];
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d & ~cs_q[STAGES-1];
  assign cs_fall   = ~cs_q[STAGES-1] & cs_d;
  assign cs_rise   = cs_q[STAGES-1] & ~cs_d;
  assign din_s     = din_q[STAGES-1];

endmodule

// File: rtl/regbus_spi_shifter.sv
module regbus_spi_shifter #(
  parameter int RX_W = 16,
  parameter int TX_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_rise,
  input  logic            cs_fall,
  input  logic            cs_rise,
  input  logic            din_s,
  input  logic [TX_W-1:0] load_word,
  output logic            dout,
  output logic [RX_W-1:0] rx_word,
  output logic            frame_ok,
  output logic            frame_abort
);

  localparam int CNT_W = $clog2(RX_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RX_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(RX_W + 1);

  logic [TX_W-1:0]  tx_q;
  logic [RX_W-1:0]  rx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_frame_q, ok_q, abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q       <= '0;
      rx_q       <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      ok_q       <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      ok_q    <= 1'b0;
      abort_q <= 1'b0;
      if (cs_fall) begin
        tx_q       <= load_word;
        cnt_q      <= '0;
        in_frame_q <= 1'b1;
      end else if (in_frame_q && cs_rise) begin
        in_frame_q <= 1'b0;
        ok_q       <= (cnt_q == CNT_FULL);
        abort_q    <= (cnt_q != CNT_FULL);
      end else if (in_frame_q && sclk_rise) begin
        rx_q <= {rx_q[RX_W-2:0], din_s};
        tx_q <= {tx_q[TX_W-2:0], 1'b0};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dout        = tx_q[TX_W-1];
  assign rx_word     = rx_q;
  assign frame_ok    = ok_q;
  assign frame_abort = abort_q;

endmodule

// File: rtl/regbus_spi_regmux.sv
module regbus_spi_regmux #(
  parameter int IDX_W    = 5,
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 16,
  parameter logic [NUM_REGS-1:0] RD_MASK = '1
) (
  input  logic [NUM_REGS*REG_W-1:0] reg_values,
  input  logic [IDX_W-1:0]          sel_idx,
  input  logic                      sel_valid,
  output logic [REG_W-1:0]          rd_word
);

  logic [REG_W-1:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    if (RD_MASK[g]) begin : g_readable
      assign bank[g] = reg_values[g*REG_W +: REG_W];
    end else begin : g_hidden
      assign bank[g] = '0;
    end
  end

  assign rd_word = sel_valid ? bank[sel_idx] : '0;

endmodule

// File: rtl/regbus_spi_slave.sv
module regbus_spi_slave #(
  parameter int ADDR_W      = 6,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = ADDR_W - 1,
  localparam int NUM_REGS   = 1 << IDX_W,
  localparam int REG_W      = 2 * BYTE_W,
  parameter logic [NUM_REGS-1:0] RD_MASK  = 32'h5F1F_3FFF,
  parameter logic [NUM_REGS-1:0] WR_MASK  = 32'hBF1F_3E00,
  parameter logic [NUM_REGS-1:0] COR_MASK = 32'h4000_01FF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  input  logic [NUM_REGS*REG_W-1:0] reg_values,
  output logic                      spi_miso,
  output logic                      wr_stb,
  output logic [IDX_W-1:0]          wr_idx,
  output logic                      wr_hi,
  output logic [BYTE_W-1:0]         wr_byte,
  output logic [NUM_REGS-1:0]       rd_ack
);
  import regbus_spi_pkg::*;

  localparam int FRAME_W = 2 + ADDR_W + BYTE_W;

  // Frame field extraction
  function automatic logic f_is_write(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1];
  endfunction

  function automatic logic [IDX_W-1:0] f_index(input logic [FRAME_W-1:0] f);
    return f[BYTE_W+1 +: IDX_W];
  endfunction

  function automatic logic f_lane(input logic [FRAME_W-1:0] f);
    return f[BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] f_payload(input logic [FRAME_W-1:0] f);
    return f[BYTE_W-1:0];
  endfunction

  function automatic logic [NUM_REGS-1:0] f_onehot(input logic [IDX_W-1:0] i);
    return {{(NUM_REGS-1){1'b0}}, 1'b1} << i;
  endfunction

  // Named internal events
  logic               sclk_rise, cs_fall, cs_rise, din_s;
  logic               frame_ok, frame_abort;
  logic [FRAME_W-1:0] rx_frame;
  logic [REG_W-1:0]   load_word;
  logic               cmd_wr, cmd_lane, cmd_write_ok, ack_due;
  logic [IDX_W-1:0]   cmd_idx;
  logic [BYTE_W-1:0]  cmd_byte;
  access_e            cmd_access;
  logic               frame_spare_unused;

  // Pending read selection (set by a complete frame) and the one being served
  logic               pend_v, served_v;
  logic [IDX_W-1:0]   pend_idx, served_idx;

  regbus_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .din       (spi_mosi),
    .sclk_rise (sclk_rise),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .din_s     (din_s)
  );

  regbus_spi_regmux #(
    .IDX_W    (IDX_W),
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .RD_MASK  (RD_MASK)
  ) u_mux (
    .reg_values (reg_values),
    .sel_idx    (pend_idx),
    .sel_valid  (pend_v),
    .rd_word    (load_word)
  );

  regbus_spi_shifter #(.RX_W(FRAME_W), .TX_W(REG_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_rise   (sclk_rise),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .din_s       (din_s),
    .load_word   (load_word),
    .dout        (spi_miso),
    .rx_word     (rx_frame),
    .frame_ok    (frame_ok),
    .frame_abort (frame_abort)
  );

  assign cmd_wr             = f_is_write(rx_frame);
  assign cmd_idx            = f_index(rx_frame);
  assign cmd_lane           = f_lane(rx_frame);
  assign cmd_byte           = f_payload(rx_frame);
  assign frame_spare_unused = rx_frame[FRAME_W-2];
  assign cmd_access         = access_of(RD_MASK[cmd_idx], WR_MASK[cmd_idx]);
  assign cmd_write_ok       = frame_ok && cmd_wr && access_writes(cmd_access);
  assign ack_due            = frame_ok && served_v && COR_MASK[served_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_idx   <= '0;
      served_v   <= 1'b0;
      served_idx <= '0;
      wr_stb     <= 1'b0;
      wr_idx     <= '0;
      wr_hi      <= 1'b0;
      wr_byte    <= '0;
      rd_ack     <= '0;
    end else begin
      wr_stb <= cmd_write_ok;
      rd_ack <= ack_due ? f_onehot(served_idx) : '0;
      if (cmd_write_ok) begin
        wr_idx  <= cmd_idx;
        wr_hi   <= cmd_lane;
        wr_byte <= cmd_byte;
      end
      if (cs_fall) begin
        served_v   <= pend_v;
        served_idx <= pend_idx;
      end
      if (frame_ok) begin
        pend_v   <= !cmd_wr;
        pend_idx <= cmd_idx;
      end
    end
  end

endmodule

// File: rtl/regbus_spi_slave_chk.sv
module regbus_spi_slave_chk #(
  parameter int IDX_W    = 5,
  parameter int NUM_REGS = 32,
  parameter logic [NUM_REGS-1:0] WR_MASK  = '1,
  parameter logic [NUM_REGS-1:0] COR_MASK = '1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_stb,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [NUM_REGS-1:0] rd_ack,
  input logic                frame_ok,
  input logic                frame_abort
);

  // R3
  wr_target_writable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> WR_MASK[wr_idx]);

  // R2
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R2
  wr_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(frame_ok));

  // R9
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_ack));

  // R9
  ack_cor_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_ack) |-> ((rd_ack & ~COR_MASK) == '0));

  // R9
  ack_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_ack) |-> $past(frame_ok));

  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> (!wr_stb && (rd_ack == '0)));

endmodule

bind regbus_spi_slave regbus_spi_slave_chk #(
  .IDX_W    (IDX_W),
  .NUM_REGS (NUM_REGS),
  .WR_MASK  (WR_MASK),
  .COR_MASK (COR_MASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_stb      (wr_stb),
  .wr_idx      (wr_idx),
  .rd_ack      (rd_ack),
  .frame_ok    (frame_ok),
  .frame_abort (frame_abort)
);

// File: tb/regbus_spi_slave_bench.sv
`timescale 1ns/1ps
module regbus_spi_slave_bench;

  localparam int HALF = 4;  // system clocks per serial half period

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic [511:0] reg_values;
  logic         spi_miso, wr_stb, wr_hi;
  logic [4:0]   wr_idx;
  logic [7:0]   wr_byte;
  logic [31:0]  rd_ack;

  logic [15:0]  regs [32];
  int           checks = 0, fails = 0, wr_seen = 0, ack_seen = 0;
  bit           done = 1'b0;
  string        cur_req = "R1";
  bit [13:0]    exp_wr [$];
  int           exp_ack [$];
  bit           pend_v = 1'b0;
  int           pend_i = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < 32; g++) begin : g_bank
    assign reg_values[g*16 +: 16] = regs[g];
  end

  regbus_spi_slave u_regbus_spi_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .reg_values(reg_values), .spi_miso(spi_miso),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_byte(wr_byte),
    .rd_ack(rd_ack)
  );

  // Address classes, restated from the requirements by byte address
  function automatic bit readable(input int i);
    int a = 2 * i;
    return (a <= 'h10) || (a >= 'h12 && a <= 'h1A) || (a >= 'h20 && a <= 'h28) ||
           (a >= 'h30 && a <= 'h38) || (a == 'h3C);
  endfunction

  function automatic bit writable(input int i);
    int a = 2 * i;
    return (a >= 'h12 && a <= 'h1A) || (a >= 'h20 && a <= 'h28) ||
           (a >= 'h30 && a <= 'h3A) || (a == 'h3E);
  endfunction

  function automatic bit clears_on_read(input int i);
    int a = 2 * i;
    return (a <= 'h10) || (a == 'h3C);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of strobes and acknowledges against the model queues
  always @(negedge clk) begin : mon
    bit [13:0] e;
    int        a;
    if (rst_n) begin
      if (wr_stb) begin
        wr_seen++;
        if (exp_wr.size() == 0) check(1'b0, cur_req, {18'd0, wr_idx, wr_hi, wr_byte}, 32'd0);
        else begin
          e = exp_wr.pop_front();
          check({wr_idx, wr_hi, wr_byte} == e, "R2", {18'd0, wr_idx, wr_hi, wr_byte}, {18'd0, e});
        end
      end
      if (rd_ack != '0) begin
        ack_seen++;
        if (exp_ack.size() == 0) check(1'b0, cur_req, rd_ack, 32'd0);
        else begin
          a = exp_ack.pop_front();
          check(rd_ack == (32'd1 << a), "R9", rd_ack, 32'd1 << a);
        end
        // owner behaviour: flag in bit 15 clears on acknowledge
        for (int i = 0; i < 32; i++) if (rd_ack[i]) regs[i][15] = 1'b0;
      end
    end
  end

  task automatic xfer(input bit wr, input bit b14, input bit [5:0] addr, input bit [7:0] data,
                      input int nbits, input string req);
    bit [15:0] cmd, exp_word, got;
    int        ws0, as0, nw, na;
    cmd = {wr, b14, addr, data};
    cur_req = req;
    got = '0;
    nw = 0;
    na = 0;
    exp_word = (pend_v && readable(pend_i)) ? regs[pend_i] : 16'h0;
    if (nbits == 16) begin
      if (wr && writable(int'(addr[5:1]))) begin
        exp_wr.push_back({addr[5:1], addr[0], data});
        nw = 1;
      end
      if (pend_v && clears_on_read(pend_i)) begin
        exp_ack.push_back(pend_i);
        na = 1;
      end
    end
    ws0 = wr_seen;
    as0 = ack_seen;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      spi_sclk = 1'b0;
      spi_mosi = (k < 16) ? cmd[15-k] : 1'b0;
      repeat (HALF) @(negedge clk);
      got = {got[14:0], spi_miso};
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    if (nbits == 16) begin
      check(got == exp_word, req, {16'd0, got}, {16'd0, exp_word});
      pend_v = !wr;
      pend_i = int'(addr[5:1]);
    end
    check(wr_seen - ws0 == nw, req, wr_seen - ws0, nw);
    check(ack_seen - as0 == na, req, ack_seen - as0, na);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 32; i++) regs[i] = 16'h8000 | (16'(i * 291 + 65) & 16'h3FFF);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(wr_stb == 1'b0, "R1", wr_stb, 0);
    check(rd_ack == '0, "R1", rd_ack, 0);
    check(spi_miso == 1'b0, "R1", spi_miso, 0);

    xfer(1'b0, 1'b0, 6'h04, 8'hFF, 16, "R1");   // returns zeros, selects reg 2
    xfer(1'b0, 1'b0, 6'h10, 8'h00, 16, "R5");   // returns reg 2 with flag, ack R9
    xfer(1'b0, 1'b0, 6'h05, 8'h00, 16, "R9");   // reg 8 back; odd address selects reg 2
    xfer(1'b1, 1'b1, 6'h12, 8'h5A, 16, "R10");  // reg 2 with flag cleared, write low byte
    xfer(1'b1, 1'b0, 6'h13, 8'hC3, 16, "R8");   // zeros after write, high-byte write
    xfer(1'b1, 1'b0, 6'h04, 8'h11, 16, "R3");   // read-only: ignored
    xfer(1'b1, 1'b0, 6'h3C, 8'h22, 16, "R3");
    xfer(1'b1, 1'b0, 6'h1C, 8'h33, 16, "R4");   // unused addresses
    xfer(1'b1, 1'b0, 6'h1F, 8'h44, 16, "R4");
    xfer(1'b1, 1'b0, 6'h2A, 8'h55, 16, "R4");
    xfer(1'b1, 1'b0, 6'h2F, 8'h66, 16, "R4");
    xfer(1'b1, 1'b1, 6'h3E, 8'h80, 16, "R2");   // write-only command register
    xfer(1'b0, 1'b0, 6'h3A, 8'h00, 16, "R2");   // select write-only reg
    xfer(1'b0, 1'b0, 6'h2C, 8'h00, 16, "R6");   // zeros; select unused
    xfer(1'b0, 1'b0, 6'h12, 8'h00, 16, "R6");   // zeros; select plain RW reg 9
    xfer(1'b0, 1'b0, 6'h08, 8'h00, 16, "R9");   // reg 9 value, no ack
    xfer(1'b1, 1'b0, 6'h20, 8'h77, 8,  "R7");   // short frame discarded
    xfer(1'b1, 1'b0, 6'h22, 8'h78, 17, "R7");   // long frame discarded
    xfer(1'b0, 1'b0, 6'h0A, 8'h00, 16, "R7");   // still returns reg 4 with ack
    regs[5] = 16'h9ABC;
    xfer(1'b0, 1'b0, 6'h3C, 8'h00, 16, "R11");  // fresh reg 5 value
    xfer(1'b0, 1'b0, 6'h00, 8'h00, 16, "R9");   // status reg 30 with ack
    check(exp_wr.size() == 0, "R2", exp_wr.size(), 0);
    check(exp_ack.size() == 0, "R9", exp_ack.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule